// File: doc/BRIEF.md
# Key Matrix Encoder with Maskable Key Interrupt

This block connects a front-panel key matrix to a small 8-bit processor through its I/O space. It takes eight column lines and eight row lines. Each group is reduced to a 3-bit index. Those two indices and a filtered "key is down" flag are packed into one status byte, which the processor fetches by an I/O read at a fixed port address. Outside that read, the data output is held at zero and its enable is low, so the output can be merged onto a shared read bus.

The "key is down" condition is true when at least one column line and at least one row line are asserted. A counter filters this condition before it is used, so contact bounce yields a single clean edge. The filtered flag drives an active-low interrupt request. Software gates that request with one bit in a control port at a second I/O address. That bit is cleared by reset, so the interrupt starts out masked.

Top module: `kbd_matrix_irq`

## Requirements
- R1: Status byte bits [2:0] hold the index of the lowest-numbered asserted column line (`key_x`). When no column line is asserted they are 0.
- R2: Status byte bits [5:3] hold the index of the lowest-numbered asserted row line (`key_y`). When no row line is asserted they are 0.
- R3: Status byte bit 6 is the filtered key-down flag. Bit 7 always reads 0.
- R4: `io_rdata_en` is 1 and `io_rdata` carries the status byte only while `io_rd` is 1 and `io_addr` is 0xE0. In every other cycle `io_rdata` is 0x00 and `io_rdata_en` is 0.
- R5: The raw key-down condition is (any `key_x` bit set) AND (any `key_y` bit set). The filtered flag takes the new raw level at the 17th rising edge after the raw level changes, provided the raw level has held for that whole span (default filter length 16). The flag is 0 after reset.
- R6: A raw level that reverts before the filter length has elapsed leaves the filtered flag unchanged.
- R7: A write (`io_wr` = 1) to address 0xF2 loads the mask bit from `io_wdata` bit 3 at that clock edge. All other data bits, and writes to any other address, do not change the mask. The mask is 0 after reset.
- R8: `irq_n` is 0 exactly when the filtered flag is 1 and the mask bit is 1. Otherwise it is 1, and it is 1 after reset.
- R9: `irq_n` returns to 1 one edge after a write that clears the mask bit. When the key is released, it returns to 1 after the filter delay of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| io_wdata | input | 8 | I/O write data |
| key_x | input | 8 | Column lines of the key matrix, active high |
| key_y | input | 8 | Row lines of the key matrix, active high |
| io_rdata | output | 8 | Status byte during a status read, else 0 |
| io_rdata_en | output | 1 | High while the status byte is driven |
| irq_n | output | 1 | Key interrupt request, active low |

## Verification
The bench goes after multi-hot groups. An encoder that picks the highest line, or ORs the indices together, returns a wrong code there. It probes the exact filter edge: a filter that is one cycle short or long shows the flag one read too early, or still missing one read late. A press on one axis only must leave the flag low, which catches a raw flag built from a single group. The bench also writes the control port with bit 3 clear and all other bits set, and writes other addresses. A design that decodes the wrong bit, or decodes the address loosely, then flips `irq_n` when it should not.

// File: rtl/kbd_pkg.sv
// Package kbd_pkg
// Shared constants for the key matrix encoder: default port addresses,
// default mask bit position and bus width. Assumes an 8-bit I/O space.
package kbd_pkg;
    localparam int unsigned BUS_W          = 8;
    localparam logic [7:0]  STATUS_PORT    = 8'hE0;
    localparam logic [7:0]  CONTROL_PORT   = 8'hF2;
    localparam int unsigned MASK_BIT_POS   = 3;
    localparam int unsigned FILTER_DEFAULT = 16;
endpackage

// File: rtl/kbd_prio_enc.sv
// Module kbd_prio_enc
// Reduces a group of key lines to the binary index of the lowest-numbered
// asserted line. With no line asserted the code is 0 and any_set is 0.
// Assumes N_LINES >= 2. Purely combinational.
module kbd_prio_enc #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned CODE_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] lines,
    output logic [CODE_W-1:0]  code,
    output logic               any_set
);
    // Scan from the top down so that the lowest asserted line is written last.
    always_comb begin
        code = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (lines[i]) begin
                code = CODE_W'(i);
            end
        end
    end

    // Group activity flag.
    assign any_set = |lines;
endmodule

// File: rtl/kbd_debounce.sv
// Module kbd_debounce
// Level filter. The raw input is registered once. The filtered level
// follows the registered level only after the two have differed for
// FILTER_LEN consecutive clock edges. Any agreement restarts the count.
// Assumes FILTER_LEN >= 2. Synchronous active-low reset; output resets to 0.
module kbd_debounce #(
    parameter int unsigned FILTER_LEN = 16,
    localparam int unsigned CNT_W = $clog2(FILTER_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_LEN - 1);

    logic             raw_q;
    logic [CNT_W-1:0] cnt_q;
    logic             level_q;
    logic             differ;

    assign differ = (raw_q != level_q);

    // Sample the raw level once, so that the filter sees a clean register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else begin
            raw_q <= raw;
        end
    end

    // Count disagreeing cycles and move the filtered level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (!differ) begin
            cnt_q   <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            level_q <= raw_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/kbd_io_ctrl.sv
// Module kbd_io_ctrl
// I/O side of the encoder. It decodes the status read and the control
// write, holds the interrupt mask bit, and selects the read data.
// Assumes single-cycle strobes and a full address decode.
module kbd_io_ctrl #(
    parameter int unsigned  BUS_W     = 8,
    parameter logic [BUS_W-1:0] RD_PORT = 8'hE0,
    parameter logic [BUS_W-1:0] WR_PORT = 8'hF2,
    parameter int unsigned  MASK_POS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [BUS_W-1:0] io_wdata,
    input  logic [BUS_W-1:0] status,
    output logic [BUS_W-1:0] io_rdata,
    output logic             io_rdata_en,
    output logic             mask_en
);
    logic rd_hit;
    logic wr_hit;
    logic mask_q;
    logic unused_wdata;

    assign rd_hit = io_rd && (io_addr == RD_PORT);
    assign wr_hit = io_wr && (io_addr == WR_PORT);

    // Only the mask bit is stored; the other data bits are left unused.
    assign unused_wdata = ^io_wdata;

    // Mask bit register, loaded by a control port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr_hit) begin
            mask_q <= io_wdata[MASK_POS];
        end
    end

    // Read data select: the status byte on a hit, otherwise zero.
    always_comb begin
        io_rdata    = '0;
        io_rdata_en = 1'b0;
        if (rd_hit) begin
            io_rdata    = status;
            io_rdata_en = 1'b1;
        end
    end

    assign mask_en = mask_q;
endmodule

// File: rtl/kbd_matrix_irq.sv
// Module kbd_matrix_irq
// Top of the key matrix encoder. It encodes the column and row groups,
// filters the key-down condition, builds the status byte
// {0, flag, row code, column code}, and raises an active-low interrupt
// while the filtered flag and the mask bit are both set.
// Assumes 2*log2(N_LINES)+1 <= BUS_W and matrix lines already synchronous.
module kbd_matrix_irq
    import kbd_pkg::*;
#(
    parameter int unsigned N_LINES    = 8,
    parameter int unsigned FILTER_LEN = FILTER_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [BUS_W-1:0] io_wdata,
    input  logic [N_LINES-1:0] key_x,
    input  logic [N_LINES-1:0] key_y,
    output logic [BUS_W-1:0] io_rdata,
    output logic             io_rdata_en,
    output logic             irq_n
);
    localparam int unsigned CODE_W   = $clog2(N_LINES);
    localparam int unsigned FIELD_W  = 2 * CODE_W + 1;
    localparam int unsigned N_GROUPS = 2;

    logic [N_LINES-1:0] grp_lines [N_GROUPS];
    logic [CODE_W-1:0]  grp_code  [N_GROUPS];
    logic               grp_any   [N_GROUPS];
    logic               key_raw;
    logic               key_flt;
    logic               mask_en;
    logic [BUS_W-1:0]   status;

    assign grp_lines[0] = key_x;
    assign grp_lines[1] = key_y;

    // One priority encoder for each axis of the matrix.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_axis
        kbd_prio_enc #(.N_LINES(N_LINES)) u_enc (
            .lines   (grp_lines[g]),
            .code    (grp_code[g]),
            .any_set (grp_any[g])
        );
    end

    // A key counts as down only when both axes show activity.
    assign key_raw = grp_any[0] && grp_any[1];

    kbd_debounce #(.FILTER_LEN(FILTER_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (key_raw),
        .level (key_flt)
    );

    // Status byte: column code low, row code above it, flag on top, rest zero.
    assign status = BUS_W'({key_flt, grp_code[1], grp_code[0]});

    kbd_io_ctrl #(
        .BUS_W    (BUS_W),
        .RD_PORT  (STATUS_PORT),
        .WR_PORT  (CONTROL_PORT),
        .MASK_POS (MASK_BIT_POS)
    ) u_io (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_addr     (io_addr),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .io_wdata    (io_wdata),
        .status      (status),
        .io_rdata    (io_rdata),
        .io_rdata_en (io_rdata_en),
        .mask_en     (mask_en)
    );

    // Interrupt request, active low, gated by the mask bit.
    assign irq_n = !(key_flt && mask_en);

    logic unused_width;
    assign unused_width = (FIELD_W > BUS_W);
endmodule

// File: rtl/kbd_matrix_irq_chk.sv
// Module kbd_matrix_irq_chk
// Assertion checker bound to kbd_matrix_irq. It watches the I/O ports,
// the filtered flag and the mask bit. A local run counter measures how
// long the raw key-down condition has held.
module kbd_matrix_irq_chk #(
    parameter int unsigned N_LINES    = 8,
    parameter int unsigned FILTER_LEN = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         io_addr,
    input logic               io_rd,
    input logic               io_wr,
    input logic [7:0]         io_wdata,
    input logic [N_LINES-1:0] key_x,
    input logic [N_LINES-1:0] key_y,
    input logic [7:0]         io_rdata,
    input logic               io_rdata_en,
    input logic               irq_n,
    input logic               key_flt,
    input logic               mask_en
);
    localparam int unsigned RUN_W = $clog2(FILTER_LEN + 1);

    logic             raw_now;
    logic             raw_d;
    logic [RUN_W-1:0] run_q;

    assign raw_now = (|key_x) && (|key_y);

    // Count how many edges the raw condition has held, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_d <= 1'b0;
            run_q <= '0;
        end else begin
            raw_d <= raw_now;
            if (raw_now != raw_d) begin
                run_q <= '0;
            end else if (run_q != RUN_W'(FILTER_LEN)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == 8'hE0) |-> (io_rdata == 8'h00 && !io_rdata_en)); // R4
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[7] == 1'b0); // R3
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 8'hF2) |=> (mask_en == $past(io_wdata[3]))); // R7
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == 8'hF2) |=> $stable(mask_en)); // R7
    AST_FLAG_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_flt) |-> (run_q >= RUN_W'(FILTER_LEN))); // R6
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> mask_en); // R8
    AST_IRQ_DROP_ON_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mask_en) |-> irq_n); // R9
endmodule

bind kbd_matrix_irq kbd_matrix_irq_chk #(
    .N_LINES    (N_LINES),
    .FILTER_LEN (FILTER_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .key_x       (key_x),
    .key_y       (key_y),
    .io_rdata    (io_rdata),
    .io_rdata_en (io_rdata_en),
    .irq_n       (irq_n),
    .key_flt     (key_flt),
    .mask_en     (mask_en)
);

// File: tb/tb_kbd_matrix_irq.sv
// Bench for kbd_matrix_irq: seeded random reads plus directed filter,
// mask and interrupt cases. Inputs change on the falling edge and
// outputs are sampled 1 ns after it.
module tb_kbd_matrix_irq;
    localparam int FILT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] key_x = 8'h00;
    logic [7:0] key_y = 8'h00;
    logic [7:0] io_rdata;
    logic       io_rdata_en;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    kbd_matrix_irq dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .key_x(key_x), .key_y(key_y),
        .io_rdata(io_rdata), .io_rdata_en(io_rdata_en), .irq_n(irq_n)
    );

    function automatic logic [2:0] low_idx(input logic [7:0] v);
        logic [2:0] r = 3'd0;
        for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Status read at the current falling edge; returns the byte seen.
    task automatic rd_status(output logic [7:0] v, output logic en);
        io_addr = 8'hE0; io_rd = 1'b1;
        #1; v = io_rdata; en = io_rdata_en;
        io_rd = 1'b0; io_addr = 8'h00;
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
        #1;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic       en;
        void'($urandom(32'd20240611));
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // Reset state
        check("R8 reset irq_n", irq_n, 1'b1);
        check("R4 idle rdata", {io_rdata_en, io_rdata}, 9'h000);
        rd_status(v, en);
        check("R5 reset flag/status", {en, v}, 9'h100);

        // Random codes, single and multi-hot, including empty groups
        for (int k = 0; k < 300; k++) begin
            logic [7:0] a;
            @(negedge clk);
            case ($urandom_range(0, 3))
                0: key_x = 8'(1 << $urandom_range(0, 7));
                1: key_x = 8'h00;
                default: key_x = 8'($urandom);
            endcase
            case ($urandom_range(0, 3))
                0: key_y = 8'(1 << $urandom_range(0, 7));
                1: key_y = 8'h00;
                default: key_y = 8'($urandom);
            endcase
            rd_status(v, en);
            check("R1 column code", v[2:0], low_idx(key_x));
            check("R2 row code", v[5:3], low_idx(key_y));
            check("R3 bit7 zero", v[7], 1'b0);
            check("R4 enable on hit", en, 1'b1);
            a = 8'($urandom);
            if (a == 8'hE0) a = 8'hE1;
            io_addr = a; io_rd = 1'b1; #1;
            check("R4 other address", {io_rdata_en, io_rdata}, 9'h000);
            io_rd = 1'b0; io_addr = 8'hE0; #1;
            check("R4 no strobe", {io_rdata_en, io_rdata}, 9'h000);
            io_addr = 8'h00;
        end
        key_x = 8'h00; key_y = 8'h00;
        cycles(3 * FILT);
        rd_status(v, en);
        check("R5 flag clear after idle", v[6], 1'b0);

        // One axis only never counts as a key
        key_x = 8'h10;
        cycles(2 * FILT);
        rd_status(v, en);
        check("R5 single axis no flag", v[6], 1'b0);
        key_x = 8'h00;

        // Mask is 0 after reset: key down must not interrupt
        key_x = 8'h04; key_y = 8'h20;
        cycles(FILT);
        rd_status(v, en);
        check("R5 flag not yet at 16 edges", v[6], 1'b0);
        cycles(1);
        rd_status(v, en);
        check("R5 flag set at 17th edge", v[6], 1'b1);
        check("R3 full status", v, 8'h6A);
        check("R7 masked after reset", irq_n, 1'b1);

        // Mask bit only via bit 3 of port F2
        io_write(8'hF2, 8'hF7);
        check("R7 other bits ignored", irq_n, 1'b1);
        io_write(8'hF2, 8'h08);
        check("R8 unmasked irq low", irq_n, 1'b0);
        io_write(8'hF3, 8'h00);
        check("R7 other address ignored", irq_n, 1'b0);
        io_write(8'h72, 8'h00);
        check("R7 partial address ignored", irq_n, 1'b0);

        // Short release glitch keeps the flag
        key_y = 8'h00;
        cycles(FILT - 6);
        key_y = 8'h20;
        cycles(2 * FILT);
        check("R6 release glitch ignored", irq_n, 1'b0);

        // Mask clear drops the request on the next edge
        io_write(8'hF2, 8'h00);
        check("R9 mask clear releases", irq_n, 1'b1);
        io_write(8'hF2, 8'hFF);
        check("R8 re-enable", irq_n, 1'b0);

        // Key release: request held for the filter span, then released
        key_x = 8'h00; key_y = 8'h00;
        cycles(FILT);
        check("R9 still low at 16 edges", irq_n, 1'b0);
        cycles(1);
        check("R9 released at 17th edge", irq_n, 1'b1);

        // Chatter shorter than the filter never raises the request
        for (int c = 0; c < 12; c++) begin
            key_x = (c % 2 == 0) ? 8'h81 : 8'h00;
            key_y = (c % 2 == 0) ? 8'h02 : 8'h00;
            cycles(FILT / 2 + (c % 3));
            check("R6 chatter no irq", irq_n, 1'b1);
        end
        key_x = 8'h00; key_y = 8'h00;
        cycles(2 * FILT);
        rd_status(v, en);
        check("R6 flag still clear", v[6], 1'b0);

        finish_run();
    end
endmodule